// File: doc/BRIEF.md
# Interrupt Routing Table Scanner

This block searches a read-only memory window for an interrupt routing table and reports where the first valid one starts. A single start pulse launches the search. The caller may also supply a preferred base address with a qualifier flag. If that address is given, it is examined first. If it fails, the block walks 16-byte-aligned candidate bases from the low end of the scan window up to, but not including, the window end.

The block reads the memory one byte per cycle through a synchronous read port with one cycle of latency. For each candidate it first examines an eight-byte header. The header holds a four-byte signature at offsets 0 to 3, a 16-bit version at offsets 4 to 5 and a 16-bit length at offsets 6 to 7, all little-endian. If the header is good, the block reads the rest of the table and keeps an 8-bit running sum over every byte. A candidate that fails any check is dropped at once, and the next candidate starts.

When the search ends, done rises and stays high. found and the table address stay valid until the next accepted start.

Top module: `irqtab_scan`

## Requirements
- R1: After reset, done, found, tbl_addr and rd_en are all zero.
- R2: Header bytes at offsets 0, 1, 2 and 3 must read 0x24, 0x50, 0x49 and 0x52 (value 0x52495024 little-endian); any other byte rejects the candidate.
- R3: The version, read little-endian from offsets 4 (low byte) and 5 (high byte), must equal 0x0100; otherwise the candidate is rejected.
- R4: The length, read little-endian from offsets 6 (low byte) and 7 (high byte), must be a multiple of 16 and at least 32; otherwise the candidate is rejected.
- R5: The 8-bit wrap-around sum of the first length bytes, counted from the candidate base, must be zero; otherwise the candidate is rejected.
- R6: When pref_vld is high with the start pulse, the candidate at pref_addr is checked first. If it passes, tbl_addr equals pref_addr, even when that address is unaligned or lies outside the scan window.
- R7: When there is no preferred address, or the preferred candidate fails, candidates run from SCAN_BASE upward in steps of 16 while they are below SCAN_END. The lowest passing candidate is reported with done=1 and found=1.
- R8: If no candidate passes, done=1, found=0 and tbl_addr=0.
- R9: A start pulse while a search is running is ignored. After done, the outputs hold until the next start, and an accepted start clears done on the following cycle.
- R10: rd_data is taken one cycle after rd_en. For each candidate, reads never pass base+length-1, so a search that accepts a table ends with its highest read at base+length-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, acted on only while idle |
| pref_vld | input | 1 | pref_addr is to be tried first |
| pref_addr | input | ADDR_W | Preferred table base |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_data | input | 8 | Read data, one cycle after rd_en |
| done | output | 1 | Search finished (held) |
| found | output | 1 | A valid table was found (held) |
| tbl_addr | output | ADDR_W | Base of the found table, zero if none |

## Verification
Some properties are checked on every cycle. While scanning, the candidate base stays aligned and inside the window. A preferred address is loaded as the first candidate. No read is issued while idle. The outputs stay stable between searches, and a failed search reports a zero address.

Other behaviour only shows up in the bench scenarios. That covers the rejection of each malformed header field and of a bad checksum, the choice of the lowest valid candidate, and the precedence of the preferred address. It also covers a start pulse ignored mid-search and the exact last byte read for an accepted table.

// File: rtl/irqtab_pkg.sv
package irqtab_pkg;
  localparam logic [31:0] TBL_SIG   = 32'h5249_5024;
  localparam logic [15:0] TBL_VER   = 16'h0100;
  localparam int          HDR_BYTES = 8;
  localparam int          LEN_W     = 16;

  function automatic logic [7:0] sig_byte(input logic [1:0] idx);
    return TBL_SIG[{idx, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/irqtab_field_chk.sv
module irqtab_field_chk #(
  parameter int MIN_LEN = 32,
  parameter int ALIGN   = 16
) (
  input  logic [2:0]                    off_i,
  input  logic [7:0]                    byte_i,
  input  logic [7:0]                    ver_lo_i,
  input  logic [7:0]                    len_lo_i,
  output logic                          bad_o,
  output logic [irqtab_pkg::LEN_W-1:0]  len_o
);
  localparam int AL_BITS = $clog2(ALIGN);

  always_comb begin
    len_o = {byte_i, len_lo_i};
    bad_o = 1'b0;
    case (off_i)
      3'd0, 3'd1, 3'd2, 3'd3: bad_o = (byte_i != irqtab_pkg::sig_byte(off_i[1:0]));
      3'd5:                   bad_o = ({byte_i, ver_lo_i} != irqtab_pkg::TBL_VER);
      3'd7:                   bad_o = (len_o[AL_BITS-1:0] != '0) ||
                                      (len_o < irqtab_pkg::LEN_W'(MIN_LEN));
      default:                bad_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqtab_cand_seq.sv
module irqtab_cand_seq #(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SCAN_BASE = 32'h000F_0000,
  parameter int unsigned SCAN_END  = 32'h0010_0000,
  parameter int unsigned STEP      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              pref_vld_i,
  input  logic [ADDR_W-1:0] pref_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] cand_o,
  output logic              pref_phase_o,
  output logic              last_o
);
  localparam int CW = ADDR_W + 1;

  logic [CW-1:0] cand_q;
  logic [CW-1:0] next_w;
  logic          pref_q;

  assign next_w       = cand_q + CW'(STEP);
  assign last_o       = !pref_q && (next_w >= CW'(SCAN_END));
  assign cand_o       = cand_q[ADDR_W-1:0];
  assign pref_phase_o = pref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      pref_q <= 1'b0;
    end else if (load_i) begin
      pref_q <= pref_vld_i;
      cand_q <= pref_vld_i ? {1'b0, pref_addr_i} : CW'(SCAN_BASE);
    end else if (adv_i) begin
      pref_q <= 1'b0;
      cand_q <= pref_q ? CW'(SCAN_BASE) : next_w;
    end
  end
endmodule

// File: rtl/irqtab_scan.sv
module irqtab_scan #(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SCAN_BASE = 32'h000F_0000,
  parameter int unsigned SCAN_END  = 32'h0010_0000,
  parameter int unsigned STEP      = 16,
  parameter int          MIN_LEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pref_vld,
  input  logic [ADDR_W-1:0] pref_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] tbl_addr
);
  import irqtab_pkg::*;

  localparam logic [LEN_W-1:0] HDR_LIM = LEN_W'(HDR_BYTES);

  logic              busy_q, rvld_q, hdr_ok_q;
  logic [LEN_W-1:0]  iss_q, rcv_q, len_q, lim_w;
  logic [7:0]        sum_q, sum_nx, ver_lo_q, len_lo_q;
  logic              done_q, found_q;
  logic [ADDR_W-1:0] addr_q;

  logic [ADDR_W-1:0] cand_w;
  logic              pref_phase_w, last_w;
  logic              fld_bad_w;
  logic [LEN_W-1:0]  fld_len_w;

  logic in_hdr, at_end, hdr_bad, sum_end, accept, reject, launch, adv;

  assign launch = !busy_q && start;
  assign lim_w  = hdr_ok_q ? len_q : HDR_LIM;
  assign rd_en  = busy_q && (iss_q < lim_w);
  assign rd_addr = cand_w + ADDR_W'(iss_q);

  assign in_hdr  = (rcv_q < HDR_LIM);
  assign at_end  = hdr_ok_q && (rcv_q == len_q - LEN_W'(1));
  assign sum_nx  = sum_q + rd_data;
  assign hdr_bad = rvld_q && in_hdr && fld_bad_w;
  assign sum_end = rvld_q && at_end;
  assign accept  = busy_q && sum_end && (sum_nx == 8'h00);
  assign reject  = busy_q && (hdr_bad || (sum_end && (sum_nx != 8'h00)));
  assign adv     = reject && !last_w;

  irqtab_field_chk #(.MIN_LEN(MIN_LEN), .ALIGN(STEP)) u_fld (
    .off_i    (rcv_q[2:0]),
    .byte_i   (rd_data),
    .ver_lo_i (ver_lo_q),
    .len_lo_i (len_lo_q),
    .bad_o    (fld_bad_w),
    .len_o    (fld_len_w)
  );

  irqtab_cand_seq #(
    .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE), .SCAN_END(SCAN_END), .STEP(STEP)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .load_i       (launch),
    .pref_vld_i   (pref_vld),
    .pref_addr_i  (pref_addr),
    .adv_i        (adv),
    .cand_o       (cand_w),
    .pref_phase_o (pref_phase_w),
    .last_o       (last_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      rvld_q   <= 1'b0;
      hdr_ok_q <= 1'b0;
      iss_q    <= '0;
      rcv_q    <= '0;
      len_q    <= '0;
      sum_q    <= '0;
      ver_lo_q <= '0;
      len_lo_q <= '0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      addr_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        found_q  <= 1'b0;
        addr_q   <= '0;
        iss_q    <= '0;
        rcv_q    <= '0;
        sum_q    <= '0;
        hdr_ok_q <= 1'b0;
        rvld_q   <= 1'b0;
      end
    end else if (accept) begin
      busy_q  <= 1'b0;
      rvld_q  <= 1'b0;
      done_q  <= 1'b1;
      found_q <= 1'b1;
      addr_q  <= cand_w;
    end else if (reject) begin
      iss_q    <= '0;
      rcv_q    <= '0;
      sum_q    <= '0;
      hdr_ok_q <= 1'b0;
      rvld_q   <= 1'b0;
      if (last_w) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        found_q <= 1'b0;
        addr_q  <= '0;
      end
    end else begin
      iss_q  <= iss_q + LEN_W'(rd_en);
      rvld_q <= rd_en;
      if (rvld_q) begin
        rcv_q <= rcv_q + LEN_W'(1);
        sum_q <= sum_nx;
        if (rcv_q == LEN_W'(4)) ver_lo_q <= rd_data;
        if (rcv_q == LEN_W'(6)) len_lo_q <= rd_data;
        if (rcv_q == LEN_W'(7)) begin
          len_q    <= fld_len_w;
          hdr_ok_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign found    = found_q;
  assign tbl_addr = addr_q;
endmodule

// File: rtl/irqtab_scan_chk.sv
module irqtab_scan_chk #(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SCAN_BASE = 32'h000F_0000,
  parameter int unsigned SCAN_END  = 32'h0010_0000,
  parameter int unsigned STEP      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              pref_vld,
  input logic [ADDR_W-1:0] pref_addr,
  input logic              rd_en,
  input logic              done,
  input logic              found,
  input logic [ADDR_W-1:0] tbl_addr,
  input logic              busy,
  input logic [ADDR_W-1:0] cand,
  input logic              pref_phase
);
  localparam int CW = ADDR_W + 1;

  // R7: window candidates stay aligned and in range
  assert_scan_window_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !pref_phase) |-> ((CW'(cand) >= CW'(SCAN_BASE)) && (CW'(cand) < CW'(SCAN_END)) &&
                               ((cand % ADDR_W'(STEP)) == '0)));

  // R6: a preferred address is the first candidate
  assert_pref_first_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && pref_vld) |=> (busy && pref_phase && cand == $past(pref_addr)));

  // R8: a failed search reports address zero
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (tbl_addr == '0));

  // R9: outputs hold while idle without a start
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(done) && $stable(found) && $stable(tbl_addr)));

  // R9: done only while idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: no read while idle
  assert_no_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

bind irqtab_scan irqtab_scan_chk #(
  .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE), .SCAN_END(SCAN_END), .STEP(STEP)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .pref_vld(pref_vld), .pref_addr(pref_addr),
  .rd_en(rd_en), .done(done), .found(found), .tbl_addr(tbl_addr),
  .busy(busy_q), .cand(cand_w), .pref_phase(pref_phase_w)
);

// File: tb/irqtab_scan_bench.sv
`timescale 1ns/1ps
module irqtab_scan_bench;
  localparam int unsigned BASE = 32'h000F_0000;
  localparam int unsigned WEND = 32'h000F_0800;
  localparam int          MEMSZ = 4096;

  typedef struct {
    bit          f;
    logic [19:0] a;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pref_vld = 1'b0;
  logic [19:0] pref_addr = '0;
  logic        rd_en;
  logic [19:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done, found;
  logic [19:0] tbl_addr;

  logic [7:0]  mem [0:MEMSZ-1];
  exp_t        sb_q[$];
  int          n_run = 0;
  int          n_fail = 0;
  logic        done_d = 1'b0;
  logic [19:0] max_rd = '0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  irqtab_scan #(.SCAN_END(WEND)) u_irqtab_scan (
    .clk(clk), .rst(rst), .start(start), .pref_vld(pref_vld), .pref_addr(pref_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .found(found), .tbl_addr(tbl_addr)
  );

  // memory model: one cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      if (rd_addr >= 20'(BASE) && rd_addr < 20'(BASE + MEMSZ))
        rd_data <= mem[rd_addr - 20'(BASE)];
      else
        rd_data <= 8'hFF;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when done rises, tracks read addresses
  always @(negedge clk) begin
    if (!rst && rd_en && rd_addr > max_rd) max_rd <= rd_addr;
    if (!rst && done && !done_d) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "unexpected done", 32'(tbl_addr), 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(found == e.f, {e.tag, " found"}, 32'(found), 32'(e.f));
        check(tbl_addr == e.a, {e.tag, " tbl_addr"}, 32'(tbl_addr), 32'(e.a));
      end
    end
    done_d <= done;
  end

  task automatic clear_mem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
  endtask

  task automatic put_table(input int unsigned a, input int sz, input logic [15:0] ver,
                           input bit bad_sum, input logic [7:0] sig3);
    int   o;
    logic [7:0] s;
    o = int'(a - BASE);
    mem[o+0] = 8'h24; mem[o+1] = 8'h50; mem[o+2] = 8'h49; mem[o+3] = sig3;
    mem[o+4] = ver[7:0];  mem[o+5] = ver[15:8];
    mem[o+6] = 8'(sz);    mem[o+7] = 8'(sz >> 8);
    for (int i = 8; i < sz; i++) mem[o+i] = 8'(i * 13 + int'(a));
    mem[o+8] = 8'h00;
    s = 8'h00;
    for (int i = 0; i < sz; i++) s = s + mem[o+i];
    mem[o+8] = 8'h00 - s + (bad_sum ? 8'h01 : 8'h00);
  endtask

  task automatic launch(input bit pv, input logic [19:0] pa);
    @(negedge clk);
    max_rd    = '0;
    start     = 1'b1;
    pref_vld  = pv;
    pref_addr = pa;
    @(negedge clk);
    start    = 1'b0;
    pref_vld = 1'b0;
  endtask

  task automatic search(input bit pv, input logic [19:0] pa, input bit ef,
                        input logic [19:0] ea, input string tag);
    exp_t e;
    e.f = ef; e.a = ea; e.tag = tag;
    sb_q.push_back(e);
    launch(pv, pa);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    clear_mem();
    repeat (3) @(negedge clk);
    check(done == 0 && found == 0 && tbl_addr == 0 && rd_en == 0, "R1 in reset",
          {found, done, rd_en, 9'h0, tbl_addr}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && found == 0 && tbl_addr == 0 && rd_en == 0, "R1 after reset",
          {found, done, rd_en, 9'h0, tbl_addr}, 32'h0);

    // R8: empty memory
    search(0, '0, 0, '0, "R8 empty");

    // R7 R2 R3 R4 R5: single valid table, R10 last read
    clear_mem(); put_table(32'hF0100, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 1, 20'hF0100, "R7 single");
    check(max_rd == 20'hF011F, "R10 last read 32", 32'(max_rd), 32'hF011F);

    // R5: bad checksum skipped
    clear_mem(); put_table(32'hF0080, 32, 16'h0100, 1, 8'h52);
    put_table(32'hF0200, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 1, 20'hF0200, "R5 bad sum skipped");

    // R3: bad version skipped
    clear_mem(); put_table(32'hF0040, 32, 16'h0101, 0, 8'h52);
    put_table(32'hF0300, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 1, 20'hF0300, "R3 bad version");

    // R4: length not multiple of 16, and too short
    clear_mem(); put_table(32'hF0040, 40, 16'h0100, 0, 8'h52);
    search(0, '0, 0, '0, "R4 len 40");
    clear_mem(); put_table(32'hF0040, 16, 16'h0100, 0, 8'h52);
    search(0, '0, 0, '0, "R4 len 16");

    // R2: one signature byte wrong
    clear_mem(); put_table(32'hF0040, 32, 16'h0100, 0, 8'h53);
    put_table(32'hF0400, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 1, 20'hF0400, "R2 bad signature");

    // R7: lowest of two valid tables; R5 R10 longer table
    clear_mem(); put_table(32'hF0180, 64, 16'h0100, 0, 8'h52);
    put_table(32'hF0500, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 1, 20'hF0180, "R7 lowest wins");
    check(max_rd == 20'hF01BF, "R10 last read 64", 32'(max_rd), 32'hF01BF);

    // R6: unaligned preferred address wins over aligned one
    put_table(32'hF0705, 32, 16'h0100, 0, 8'h52);
    search(1, 20'hF0705, 1, 20'hF0705, "R6 pref unaligned");

    // R6 R7: failing preferred falls back to scan
    search(1, 20'hF0600, 1, 20'hF0180, "R6 pref fails");

    // R7 R8: table at window end is outside the scan, last candidate inside
    clear_mem(); put_table(32'hF0800, 32, 16'h0100, 0, 8'h52);
    search(0, '0, 0, '0, "R8 beyond window");
    search(1, 20'hF0800, 1, 20'hF0800, "R6 pref outside window");

    // R9: start while busy ignored, outputs hold, done clears
    clear_mem(); put_table(32'hF07F0, 32, 16'h0100, 0, 8'h52);
    put_table(32'hF0900, 32, 16'h0100, 0, 8'h52);
    begin
      exp_t e;
      logic [19:0] held;
      e.f = 1; e.a = 20'hF07F0; e.tag = "R9 busy start ignored";
      sb_q.push_back(e);
      launch(0, '0);
      check(done == 0, "R9 done cleared", 32'(done), 32'h0);
      repeat (10) @(negedge clk);
      start = 1'b1; pref_vld = 1'b1; pref_addr = 20'hF0900;
      @(negedge clk);
      start = 1'b0; pref_vld = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      held = tbl_addr;
      repeat (20) @(negedge clk);
      check(done == 1 && found == 1 && tbl_addr == held, "R9 outputs hold",
            32'(tbl_addr), 32'(held));
    end

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule